// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block is a small synchronous register whose behaviour on every rising clock edge is selected by a two-bit mode input. It can keep its contents, load a new word from its parallel inputs, or move every bit one place toward either end. When it moves bits, a dedicated serial input fills the position that falls empty. The serial input for downward moves enters at the top bit. The serial input for upward moves enters at the bottom bit.

An active-low clear zeroes the register at once, without waiting for a clock edge. The width is a parameter, with four bits as the default.

Instances chain into wider words. Each instance's edge bit is wired to the matching serial input of its neighbour. A common use is a serial link: a sending chain is loaded in parallel and shifted out one bit per cycle, and a receiving chain on the same clock collects those bits and presents them in parallel.

Top module: `shreg_top`

## Requirements
- R1: While `rstN` is low, `parOut` is all zeros. This takes effect without a clock edge and overrides every mode.
- R2: Mode 2'b00 keeps `parOut` unchanged across the clock edge.
- R3: Mode 2'b11 copies `parIn[i]` into `parOut[i]` for every bit i on the rising edge.
- R4: Mode 2'b10 moves each bit one place toward bit 0: new `parOut[i]` equals old `parOut[i+1]`. `serHiIn` enters at the top bit, and old bit 0 is dropped.
- R5: Mode 2'b01 moves each bit one place toward the top: new `parOut[i]` equals old `parOut[i-1]`. `serLoIn` enters at bit 0, and the old top bit is dropped.
- R6: The serial input that does not belong to the active mode has no effect on `parOut`. In mode 2'b10, `serLoIn` is ignored. In mode 2'b01, `serHiIn` is ignored. In modes 2'b00 and 2'b11, both serial inputs are ignored.
- R7: `parOut` changes only at a rising clock edge, or on clear. Changes to `mode` or `parIn` between edges leave it unchanged.
- R8: Two instances chained form an 8-bit register, with the upper instance's bit 0 feeding the lower instance's `serHiIn` and the lower instance's top bit feeding the upper instance's `serLoIn`. A word loaded into a sending pair arrives intact in a receiving pair after eight shifts, in either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low clear |
| mode | input | 2 | 00 hold, 01 shift toward top, 10 shift toward bit 0, 11 parallel load |
| parIn | input | WIDTH | Parallel load data |
| serHiIn | input | 1 | Serial bit entering the top position on a downward shift |
| serLoIn | input | 1 | Serial bit entering bit 0 on an upward shift |
| parOut | output | WIDTH | Register contents |

## Verification
The register is its own output, so a wrong internal state shows at `parOut` in the cycle right after the faulty edge. Nothing lies between the register and the pins to mask or delay the error.

An error in a shift is less direct. A wrong neighbour or wrong serial source corrupts only one bit position. That bit stays wrong through later holds and moves one place per shift. The stimulus sequence therefore follows shifts with further shifts, and ends with an eight-step chained transfer. Any misrouted bit in either direction then reaches a checked output.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } shMode_e;

  typedef struct packed {
    logic load;
    logic shDown;
    logic shUp;
  } shCtl_t;

endpackage

// File: rtl/shreg_ctrl.sv
module shreg_ctrl
  import shreg_pkg::*;
(
  input  logic [1:0] mode,
  output shCtl_t     ctl
);

  always_comb begin
    ctl = '0;
    unique case (shMode_e'(mode))
      MODE_LOAD: ctl.load   = 1'b1;
      MODE_DOWN: ctl.shDown = 1'b1;
      MODE_UP:   ctl.shUp   = 1'b1;
      default:   ctl        = '0;
    endcase
  end

endmodule

// File: rtl/shreg_data.sv
module shreg_data
  import shreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  shCtl_t           ctl,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serHiIn,
  input  logic             serLoIn,
  output logic [WIDTH-1:0] q
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nxt;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic fromAbove;
    logic fromBelow;
    if (i == TOP) begin : g_top
      assign fromAbove = serHiIn;
    end else begin : g_mid_hi
      assign fromAbove = q[i+1];
    end
    if (i == 0) begin : g_bot
      assign fromBelow = serLoIn;
    end else begin : g_mid_lo
      assign fromBelow = q[i-1];
    end
    assign nxt[i] = ctl.load   ? parIn[i]  :
                    ctl.shDown ? fromAbove :
                    ctl.shUp   ? fromBelow : q[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) q <= '0;
    else       q <= nxt;
  end

  assert_clear_zero_R1: assert property (@(posedge clk) !rstN |-> q == '0);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.load && !ctl.shDown && !ctl.shUp) |=> $stable(q));

  assert_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.load |=> q == $past(parIn));

  assert_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shDown |=> (q[TOP] == $past(serHiIn)) && (q[TOP-1:0] == $past(q[TOP:1])));

  assert_up_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.shUp |=> (q[0] == $past(serLoIn)) && (q[TOP:1] == $past(q[TOP-1:0])));

  assert_single_op_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.load, ctl.shDown, ctl.shUp}));

endmodule

// File: rtl/shreg_top.sv
module shreg_top
  import shreg_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic [WIDTH-1:0] parIn,
  input  logic             serHiIn,
  input  logic             serLoIn,
  output logic [WIDTH-1:0] parOut
);

  shCtl_t ctl;

  shreg_ctrl u_ctrl (
    .mode (mode),
    .ctl  (ctl)
  );

  shreg_data #(.WIDTH(WIDTH)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .parIn   (parIn),
    .serHiIn (serHiIn),
    .serLoIn (serLoIn),
    .q       (parOut)
  );

endmodule

// File: tb/tb_shreg_top.sv
`timescale 1ns/1ps
module tb_shreg_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN;
  logic [1:0] mode;
  logic [3:0] parIn;
  logic       serHiIn, serLoIn;
  logic [3:0] parOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  shreg_top #(.WIDTH(4)) dut (
    .clk(clk), .rstN(rstN), .mode(mode), .parIn(parIn),
    .serHiIn(serHiIn), .serLoIn(serLoIn), .parOut(parOut)
  );

  // Cascade for R8: sender pair and receiver pair on the same clock
  logic [1:0] sendMode, recvMode;
  logic [7:0] sendLoad;
  logic [3:0] sLoQ, sHiQ, rLoQ, rHiQ;

  shreg_top #(.WIDTH(4)) sendHi (
    .clk(clk), .rstN(rstN), .mode(sendMode), .parIn(sendLoad[7:4]),
    .serHiIn(1'b0), .serLoIn(sLoQ[3]), .parOut(sHiQ)
  );
  shreg_top #(.WIDTH(4)) sendLo (
    .clk(clk), .rstN(rstN), .mode(sendMode), .parIn(sendLoad[3:0]),
    .serHiIn(sHiQ[0]), .serLoIn(1'b0), .parOut(sLoQ)
  );
  shreg_top #(.WIDTH(4)) recvHi (
    .clk(clk), .rstN(rstN), .mode(recvMode), .parIn(4'h0),
    .serHiIn(sLoQ[0]), .serLoIn(rLoQ[3]), .parOut(rHiQ)
  );
  shreg_top #(.WIDTH(4)) recvLo (
    .clk(clk), .rstN(rstN), .mode(recvMode), .parIn(4'h0),
    .serHiIn(rHiQ[0]), .serLoIn(sHiQ[3]), .parOut(rLoQ)
  );

  // {mode[11:10], parIn[9:6], serHiIn[5], serLoIn[4], expected[3:0]}
  localparam int NVEC = 15;
  localparam logic [11:0] VEC [NVEC] = '{
    12'b11_1011_0_0_1011,
    12'b00_0101_1_1_1011,
    12'b10_0000_0_1_0101,
    12'b10_0000_1_0_1010,
    12'b01_0000_0_1_0101,
    12'b01_0000_1_0_1010,
    12'b11_0110_1_1_0110,
    12'b01_0000_0_1_1101,
    12'b10_0000_1_0_1110,
    12'b00_1111_0_0_1110,
    12'b11_0000_1_1_0000,
    12'b01_0000_1_1_0001,
    12'b01_0000_0_1_0011,
    12'b10_0000_0_1_0001,
    12'b10_0000_0_0_0000
  };

  function automatic string tagOf(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b11:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    #100000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; mode = 2'b11; parIn = 4'hF; serHiIn = 1'b1; serLoIn = 1'b1;
    sendMode = 2'b00; recvMode = 2'b00; sendLoad = 8'h00;
    #1;
    check("R1 reset value", {4'h0, parOut}, 8'h00);
    step(); step();
    check("R1 clear overrides load", {4'h0, parOut}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      mode = VEC[k][11:10]; parIn = VEC[k][9:6];
      serHiIn = VEC[k][5];  serLoIn = VEC[k][4];
      step();
      check(tagOf(VEC[k][11:10]), {4'h0, parOut}, {4'h0, VEC[k][3:0]});
    end

    // R6: unused serial input ignored in each direction
    @(negedge clk); mode = 2'b11; parIn = 4'h0; step();
    @(negedge clk); mode = 2'b10; serHiIn = 1'b0; serLoIn = 1'b1; step();
    check("R6 serLoIn during downward shift", {4'h0, parOut}, 8'h00);
    @(negedge clk); mode = 2'b01; serHiIn = 1'b1; serLoIn = 1'b0; step();
    check("R6 serHiIn during upward shift", {4'h0, parOut}, 8'h00);

    // R7: mid-cycle input changes do not alter the output
    @(negedge clk); mode = 2'b11; parIn = 4'h9; step();
    mode = 2'b11; parIn = 4'h6;
    #1;
    check("R7 output stable between edges", {4'h0, parOut}, 8'h09);
    @(negedge clk); mode = 2'b00;
    step();
    check("R7 hold after mid-cycle change", {4'h0, parOut}, 8'h09);

    // R1: asynchronous clear mid-cycle
    @(negedge clk); rstN = 1'b0;
    #1;
    check("R1 clear without clock edge", {4'h0, parOut}, 8'h00);
    @(negedge clk); rstN = 1'b1;

    // R8: downward 8-bit transfer
    @(negedge clk); sendMode = 2'b11; sendLoad = 8'hA5; recvMode = 2'b00; step();
    check("R8 sender loaded", {sHiQ, sLoQ}, 8'hA5);
    @(negedge clk); sendMode = 2'b10; recvMode = 2'b10;
    for (int s = 0; s < 4; s++) step();
    check("R8 receiver after four downward shifts", {rHiQ, rLoQ}, 8'h50);
    check("R8 sender after four downward shifts", {sHiQ, sLoQ}, 8'h0A);
    for (int s = 0; s < 4; s++) step();
    check("R8 receiver after eight downward shifts", {rHiQ, rLoQ}, 8'hA5);
    check("R8 sender emptied downward", {sHiQ, sLoQ}, 8'h00);

    // R8: upward 8-bit transfer
    @(negedge clk); sendMode = 2'b11; sendLoad = 8'h3C; recvMode = 2'b11; step();
    @(negedge clk); sendMode = 2'b01; recvMode = 2'b01;
    for (int s = 0; s < 8; s++) step();
    check("R8 receiver after eight upward shifts", {rHiQ, rLoQ}, 8'h3C);
    check("R8 sender emptied upward", {sHiQ, sLoQ}, 8'h00);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule